// File: doc/BRIEF.md
# Token-Counting Cache Permission Tracker

This block holds the coherence state for every line of a small cache inside one node. Each line has a fixed system-wide budget of `TOKENS` tokens. The node may read a line only while it holds at least one token and valid data. It may write the line only while it holds every token and valid data. Per line, the block keeps a token count, a flag for the single owner token, and a flag that marks the data as present.

Three one-cycle commands update the state. An incoming response adds tokens, and may also bring data or the owner token. A remote request asks for read or write access, and the block answers with a grant message one cycle later. An eviction returns all held tokens to memory through a write-back message. Safety follows from the counts alone, so the order in which requests arrive never matters. The core reads its permissions combinationally for any line index.

Top module: `token_perm_tracker`

## Requirements
- R1: After reset, every line holds zero tokens, no owner token and no valid data, so read and write permission are both 0, and the `gnt_valid` and `wb_valid` outputs are 0.
- R2: `core_rd_ok` is 1 exactly when the line at `core_idx` holds one or more tokens and valid data.
- R3: `core_wr_ok` is 1 exactly when the line at `core_idx` holds all `TOKENS` tokens and valid data.
- R4: A response adds `rsp_tokens` to the line's count. The owner flag is set when `rsp_owner` is 1 and is otherwise left unchanged.
- R5: A response with `rsp_has_data`=1 and a nonzero token count sets the valid flag. A response without data leaves the flag unchanged, so a token-only message makes the line readable only if it already held valid data.
- R6: A write request (`req_write`=1) on a line with a nonzero count produces, in the next cycle, `gnt_valid`=1 with every held token, the owner flag, and `gnt_data` equal to the valid flag. The line ends empty. On a line with no tokens, there is no grant.
- R7: For a read request (`req_write`=0), behaviour depends on the count:
  - Count above 1: the line keeps one token and its owner flag, and the grant carries the remaining tokens with `gnt_owner`=0 and `gnt_data` = owner AND valid.
  - Count exactly 1 with the owner token: the grant carries that token with the owner flag and data, and the line ends empty.
  - Count 1 without the owner token, or count 0: no grant.
- R8: An eviction of a line with a nonzero count produces, in the next cycle, `wb_valid`=1 with the full count, the owner flag, and `wb_data` = owner AND valid. The line ends empty. Evicting an empty line produces no write-back.
- R9: Only one command is applied per cycle. Priority is response first, then request, then eviction, and a lower-priority command raised in the same cycle has no effect.
- R10: The token count of a line never exceeds `TOKENS`. A line that collects the whole budget reports exactly `TOKENS` tokens on write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| core_idx | input | IW | Line whose permissions are reported |
| core_rd_ok | output | 1 | Read permission for `core_idx` |
| core_wr_ok | output | 1 | Write permission for `core_idx` |
| rsp_valid | input | 1 | Incoming token/data response |
| rsp_idx | input | IW | Line of the response |
| rsp_tokens | input | CW | Tokens carried by the response |
| rsp_owner | input | 1 | Response carries the owner token |
| rsp_has_data | input | 1 | Response carries data |
| req_valid | input | 1 | Incoming remote request |
| req_idx | input | IW | Line of the request |
| req_write | input | 1 | 1 = write access, 0 = read access |
| evict_valid | input | 1 | Local eviction command |
| evict_idx | input | IW | Line to evict |
| gnt_valid | output | 1 | Grant message valid (one cycle) |
| gnt_idx | output | IW | Line of the grant |
| gnt_tokens | output | CW | Tokens sent in the grant |
| gnt_owner | output | 1 | Grant carries the owner token |
| gnt_data | output | 1 | Grant carries data |
| wb_valid | output | 1 | Write-back message valid (one cycle) |
| wb_idx | output | IW | Line written back |
| wb_tokens | output | CW | Tokens returned to memory |
| wb_owner | output | 1 | Write-back carries the owner token |
| wb_data | output | 1 | Write-back carries data |

## Verification
The assertions check these properties on every cycle:
- No response pushes a count past the budget.
- Write permission never appears without read permission.
- Every grant and every write-back carries at least one token, and the two are never issued in the same cycle.
- A read request on a multi-token line sends exactly one token fewer than the line held.

Only the directed scenarios can show the rest, because each depends on a particular history of commands:
- A token-only message does not make a line readable.
- An empty line is silent on eviction.
- A non-owner holding one token ignores a read request.
- The line contents are untouched by commands that lose the priority arbitration.

// File: rtl/token_perm_tracker.sv
module token_perm_tracker #(
  parameter int LINES  = 8,
  parameter int TOKENS = 4,
  localparam int IW = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int CW = $clog2(TOKENS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] core_idx,
  output logic          core_rd_ok,
  output logic          core_wr_ok,
  input  logic          rsp_valid,
  input  logic [IW-1:0] rsp_idx,
  input  logic [CW-1:0] rsp_tokens,
  input  logic          rsp_owner,
  input  logic          rsp_has_data,
  input  logic          req_valid,
  input  logic [IW-1:0] req_idx,
  input  logic          req_write,
  input  logic          evict_valid,
  input  logic [IW-1:0] evict_idx,
  output logic          gnt_valid,
  output logic [IW-1:0] gnt_idx,
  output logic [CW-1:0] gnt_tokens,
  output logic          gnt_owner,
  output logic          gnt_data,
  output logic          wb_valid,
  output logic [IW-1:0] wb_idx,
  output logic [CW-1:0] wb_tokens,
  output logic          wb_owner,
  output logic          wb_data
);

  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] FULL = CW'(TOKENS);

  logic [CW-1:0] cnt_q [LINES];
  logic          own_q [LINES];
  logic          vld_q [LINES];

  wire do_rsp = rsp_valid;
  wire do_req = req_valid && !rsp_valid;
  wire do_evt = evict_valid && !rsp_valid && !req_valid;

  wire [CW-1:0] req_cnt = cnt_q[req_idx];
  wire          req_own = own_q[req_idx];
  wire          req_vld = vld_q[req_idx];
  wire [CW-1:0] ev_cnt  = cnt_q[evict_idx];
  wire [CW-1:0] rsp_cnt = cnt_q[rsp_idx];

  assign core_rd_ok = vld_q[core_idx] && (cnt_q[core_idx] != '0);
  assign core_wr_ok = vld_q[core_idx] && (cnt_q[core_idx] == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        cnt_q[i] <= '0;
        own_q[i] <= 1'b0;
        vld_q[i] <= 1'b0;
      end
      gnt_valid  <= 1'b0;
      gnt_idx    <= '0;
      gnt_tokens <= '0;
      gnt_owner  <= 1'b0;
      gnt_data   <= 1'b0;
      wb_valid   <= 1'b0;
      wb_idx     <= '0;
      wb_tokens  <= '0;
      wb_owner   <= 1'b0;
      wb_data    <= 1'b0;
    end else begin
      gnt_valid <= 1'b0;
      wb_valid  <= 1'b0;
      if (do_rsp) begin
        cnt_q[rsp_idx] <= rsp_cnt + rsp_tokens;
        if (rsp_owner) own_q[rsp_idx] <= 1'b1;
        if (rsp_has_data && rsp_tokens != '0) vld_q[rsp_idx] <= 1'b1;
      end else if (do_req) begin
        gnt_idx <= req_idx;
        if (req_write) begin
          if (req_cnt != '0) begin
            gnt_valid  <= 1'b1;
            gnt_tokens <= req_cnt;
            gnt_owner  <= req_own;
            gnt_data   <= req_vld;
            cnt_q[req_idx] <= '0;
            own_q[req_idx] <= 1'b0;
            vld_q[req_idx] <= 1'b0;
          end
        end else if (req_cnt > ONE) begin
          gnt_valid  <= 1'b1;
          gnt_tokens <= req_cnt - ONE;
          gnt_owner  <= 1'b0;
          gnt_data   <= req_own && req_vld;
          cnt_q[req_idx] <= ONE;
        end else if (req_cnt == ONE && req_own) begin
          gnt_valid  <= 1'b1;
          gnt_tokens <= ONE;
          gnt_owner  <= 1'b1;
          gnt_data   <= req_vld;
          cnt_q[req_idx] <= '0;
          own_q[req_idx] <= 1'b0;
          vld_q[req_idx] <= 1'b0;
        end
      end else if (do_evt && ev_cnt != '0) begin
        wb_valid  <= 1'b1;
        wb_idx    <= evict_idx;
        wb_tokens <= ev_cnt;
        wb_owner  <= own_q[evict_idx];
        wb_data   <= own_q[evict_idx] && vld_q[evict_idx];
        cnt_q[evict_idx] <= '0;
        own_q[evict_idx] <= 1'b0;
        vld_q[evict_idx] <= 1'b0;
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ({1'b0, rsp_cnt} + {1'b0, rsp_tokens} <= {1'b0, FULL})); // R10
  AST_WR_NEEDS_RD: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr_ok |-> core_rd_ok); // R3
  AST_GNT_HAS_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt_tokens != '0); // R6
  AST_WB_HAS_TOKENS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_tokens != '0); // R8
  AST_ONE_MESSAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_valid && wb_valid)); // R9
  AST_READ_KEEPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (do_req && !req_write && req_cnt > ONE) |=> (gnt_valid && gnt_tokens == $past(req_cnt) - ONE)); // R7

endmodule

// File: tb/token_perm_tracker_tb_top.sv
`timescale 1ns/1ps
module token_perm_tracker_tb_top;
  localparam int LINES = 8;
  localparam int TOKENS = 4;
  localparam int IW = $clog2(LINES);
  localparam int CW = $clog2(TOKENS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [IW-1:0] core_idx = '0;
  logic core_rd_ok, core_wr_ok;
  logic rsp_valid = 1'b0, rsp_owner = 1'b0, rsp_has_data = 1'b0;
  logic [IW-1:0] rsp_idx = '0;
  logic [CW-1:0] rsp_tokens = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic evict_valid = 1'b0;
  logic [IW-1:0] evict_idx = '0;
  logic gnt_valid, gnt_owner, gnt_data, wb_valid, wb_owner, wb_data;
  logic [IW-1:0] gnt_idx, wb_idx;
  logic [CW-1:0] gnt_tokens, wb_tokens;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  token_perm_tracker #(.LINES(LINES), .TOKENS(TOKENS)) dut_i (
    .clk(clk), .rst_n(rst_n), .core_idx(core_idx),
    .core_rd_ok(core_rd_ok), .core_wr_ok(core_wr_ok),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_tokens(rsp_tokens),
    .rsp_owner(rsp_owner), .rsp_has_data(rsp_has_data),
    .req_valid(req_valid), .req_idx(req_idx), .req_write(req_write),
    .evict_valid(evict_valid), .evict_idx(evict_idx),
    .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .gnt_tokens(gnt_tokens),
    .gnt_owner(gnt_owner), .gnt_data(gnt_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_tokens(wb_tokens),
    .wb_owner(wb_owner), .wb_data(wb_data));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit rv, int ri, int rt, bit ro, bit rd,
                      bit qv, int qi, bit qw, bit ev, int ei);
    @(negedge clk);
    rsp_valid = rv; rsp_idx = IW'(ri); rsp_tokens = CW'(rt);
    rsp_owner = ro; rsp_has_data = rd;
    req_valid = qv; req_idx = IW'(qi); req_write = qw;
    evict_valid = ev; evict_idx = IW'(ei);
    @(negedge clk);
    rsp_valid = 1'b0; req_valid = 1'b0; evict_valid = 1'b0;
  endtask

  task automatic rsp(int i, int t, bit o, bit d);
    step(1, i, t, o, d, 0, 0, 0, 0, 0);
  endtask

  task automatic perm(string tag, int i, int rd, int wr);
    core_idx = IW'(i);
    #1;
    chk({tag, " rd"}, int'(core_rd_ok), rd);
    chk({tag, " wr"}, int'(core_wr_ok), wr);
  endtask

  task automatic exp_gnt(string tag, int v, int t, int o, int d);
    chk({tag, " gnt_valid"}, int'(gnt_valid), v);
    if (v != 0) begin
      chk({tag, " gnt_tokens"}, int'(gnt_tokens), t);
      chk({tag, " gnt_owner"}, int'(gnt_owner), o);
      chk({tag, " gnt_data"}, int'(gnt_data), d);
    end
  endtask

  task automatic exp_wb(string tag, int v, int t, int o, int d);
    chk({tag, " wb_valid"}, int'(wb_valid), v);
    if (v != 0) begin
      chk({tag, " wb_tokens"}, int'(wb_tokens), t);
      chk({tag, " wb_owner"}, int'(wb_owner), o);
      chk({tag, " wb_data"}, int'(wb_data), d);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < LINES; i++) perm("R1 reset", i, 0, 0);
    chk("R1 gnt_valid", int'(gnt_valid), 0);
    chk("R1 wb_valid", int'(wb_valid), 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    exp_wb("R8 empty evict", 0, 0, 0, 0);
  endtask

  task automatic t_fill();
    rsp(1, 1, 0, 1);
    perm("R2 one token", 1, 1, 0);
    rsp(1, 3, 1, 0);
    perm("R3 full budget", 1, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    exp_wb("R10 R4 R8 evict full", 1, TOKENS, 1, 1);
    chk("R8 wb_idx", int'(wb_idx), 1);
    perm("R8 after evict", 1, 0, 0);
  endtask

  task automatic t_token_only();
    rsp(2, 2, 0, 0);
    perm("R5 token only", 2, 0, 0);
    rsp(2, 1, 0, 1);
    perm("R5 data arrives", 2, 1, 0);
    rsp(2, 1, 0, 0);
    perm("R5 token keeps valid", 2, 1, 1);
    step(0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    exp_gnt("R6 write req", 1, TOKENS, 0, 1);
    chk("R6 gnt_idx", int'(gnt_idx), 2);
    perm("R6 after give-up", 2, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    exp_gnt("R6 write req empty", 0, 0, 0, 0);
  endtask

  task automatic t_read_req();
    rsp(3, 3, 1, 1);
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, 0);
    exp_gnt("R7 read owner many", 1, 2, 0, 1);
    perm("R7 keeps one", 3, 1, 0);
    step(0, 0, 0, 0, 0, 1, 3, 0, 0, 0);
    exp_gnt("R7 read owner last", 1, 1, 1, 1);
    perm("R7 owner gone", 3, 0, 0);
    rsp(4, 1, 0, 1);
    step(0, 0, 0, 0, 0, 1, 4, 0, 0, 0);
    exp_gnt("R7 single non-owner", 0, 0, 0, 0);
    perm("R7 non-owner kept", 4, 1, 0);
    rsp(4, 1, 0, 0);
    step(0, 0, 0, 0, 0, 1, 4, 0, 0, 0);
    exp_gnt("R7 two non-owner", 1, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 4);
    exp_wb("R8 non-owner evict", 1, 1, 0, 0);
  endtask

  task automatic t_priority();
    rsp(5, 2, 0, 1);
    rsp(6, 1, 0, 1);
    step(1, 5, 1, 0, 0, 1, 5, 1, 1, 6);
    exp_gnt("R9 rsp beats req", 0, 0, 0, 0);
    exp_wb("R9 rsp beats evict", 0, 0, 0, 0);
    perm("R9 line6 untouched", 6, 1, 0);
    step(0, 0, 0, 0, 0, 1, 6, 0, 1, 6);
    exp_wb("R9 req beats evict", 0, 0, 0, 0);
    perm("R9 line6 still held", 6, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 5);
    exp_wb("R9 line5 count", 1, 3, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_token_only();
    t_read_req();
    t_priority();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule